// File: doc/BRIEF.md
# Two-Step Single-Slope Conversion Sequencer

This block is the digital control for one column of a two-step single-slope converter with an 8-bit result. A conversion runs as two passes of sixteen clock cycles each. In the coarse pass a 4-bit counter counts down. Its value drives a one-hot 4-to-16 reference decoder, so the active reference line steps down one level per cycle. The first cycle in which the comparator reports high stores the counter value as the coarse nibble. In the fine pass the stored coarse nibble drives the decoder and holds a single reference line. The counter counts up in step with an external fine ramp, and the first comparator high stores the fine nibble.

The two nibbles are merged into the output code by subtracting the fine nibble from the coarse nibble shifted up by four bits. A single-cycle start request begins a conversion, and a single-cycle done pulse marks a valid code. The references, ramp and comparator are analog parts outside this block. The only thing the block sees of them is the digital comparator decision.

Top module: `twostep_conv_seq`

## Requirements
- R1: After reset the block is idle: busy_o, done_o and coarse_sel_o are 0, every ref_line_o bit is 0, and cnt_o is 0.
- R2: A start_i high in idle begins the coarse pass on the next edge. For 16 cycles coarse_sel_o is 1 and cnt_o counts down 15, 14, … 0, one step per cycle. During this pass ref_line_o has only bit cnt_o set.
- R3: In the coarse pass, the cnt_o value of the first cycle with cmp_i high is stored as the coarse nibble. Later comparator highs in the same pass do not change it.
- R4: If cmp_i stays low for the whole coarse pass, the coarse nibble is 0, which is the last count of that pass.
- R5: The fine pass follows directly for 16 cycles. coarse_sel_o is 0, cnt_o counts up 0 … 15, and ref_line_o has only bit (coarse nibble) set for the whole pass.
- R6: In the fine pass, the cnt_o value of the first cycle with cmp_i high is stored as the fine nibble. Later highs are ignored. If no high occurs, the fine nibble is 15.
- R7: code_o equals (coarse × 16 − fine) modulo 256 whenever done_o is high.
- R8: done_o is high for exactly one cycle, on the cycle right after the 32nd conversion cycle. busy_o is high for exactly those 32 cycles, so a conversion takes 2×16 counting cycles.
- R9: start_i while busy_o is high has no effect. The running conversion keeps its timing and result, and no new conversion follows it.
- R10: ref_line_o is one-hot while busy_o is high and all zero while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Conversion request, taken only when idle |
| cmp_i | input | 1 | Comparator decision |
| cnt_o | output | 4 | Shared step counter value |
| coarse_sel_o | output | 1 | 1 while the counter drives the decoder (coarse pass) |
| ref_line_o | output | 16 | One-hot reference line selection |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle pulse, code valid |
| code_o | output | 8 | Merged conversion result |

## Verification
The case that is hardest to reach from the ports is a comparator that goes high more than once in a pass, or that never goes high. In that case only the first-trip rule or the terminal-count rule decides the stored nibble. The bench drives the comparator from a model that watches cnt_o and coarse_sel_o. The model is swept exhaustively over all coarse thresholds, including one that never trips, and over all fine thresholds, including one that never trips. A second model produces two separate comparator spikes per pass so that the later spike must be ignored. Start requests are also injected both mid-conversion and on the final fine cycle.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_COARSE = 2'd1,
        PH_FINE   = 2'd2
    } phase_e;

endpackage

// File: rtl/tsc_step_counter.sv
module tsc_step_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         step_i,
    input  logic         down_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (step_i) begin
            cnt_d = down_i ? cnt_q - 1'b1 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign q_o = cnt_q;

endmodule

// File: rtl/tsc_ref_decoder.sv
module tsc_ref_decoder #(
    parameter  int W     = 4,
    localparam int LINES = 1 << W
) (
    input  logic [W-1:0]     sel_i,
    input  logic             en_i,
    output logic [LINES-1:0] line_o
);

    for (genvar k = 0; k < LINES; k++) begin : g_line
        assign line_o[k] = en_i && (sel_i == W'(k));
    end

endmodule

// File: rtl/tsc_nibble_merge.sv
module tsc_nibble_merge #(
    parameter  int W  = 4,
    localparam int OW = 2 * W
) (
    input  logic [W-1:0]  hi_i,
    input  logic [W-1:0]  lo_i,
    output logic [OW-1:0] code_o
);

    logic [OW-1:0] hi_ext, lo_ext;

    assign hi_ext = {hi_i, {W{1'b0}}};
    assign lo_ext = {{W{1'b0}}, lo_i};
    assign code_o = hi_ext - lo_ext;

endmodule

// File: rtl/twostep_conv_seq.sv
module twostep_conv_seq
    import tsc_pkg::*;
#(
    parameter  int NIB_W  = 4,
    localparam int LEVELS = 1 << NIB_W,
    localparam int CODE_W = 2 * NIB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              cmp_i,
    output logic [NIB_W-1:0]  cnt_o,
    output logic              coarse_sel_o,
    output logic [LEVELS-1:0] ref_line_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [CODE_W-1:0] code_o
);

    localparam logic [NIB_W-1:0] CNT_TOP = {NIB_W{1'b1}};
    localparam logic [NIB_W-1:0] CNT_BOT = {NIB_W{1'b0}};

    typedef struct packed {
        phase_e           phase;
        logic             tripped;
        logic [NIB_W-1:0] coarse;
        logic [NIB_W-1:0] fine;
        logic             done;
    } seq_t;

    seq_t s_d, s_q;

    logic             ld;
    logic [NIB_W-1:0] ld_val;
    logic             step;
    logic             down;
    logic [NIB_W-1:0] cnt;
    logic [NIB_W-1:0] dec_sel;
    logic             in_coarse;
    logic             active;

    tsc_step_counter #(.W(NIB_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (ld),
        .load_val_i (ld_val),
        .step_i     (step),
        .down_i     (down),
        .q_o        (cnt)
    );

    always_comb begin
        s_d    = s_q;
        s_d.done = 1'b0;
        ld     = 1'b0;
        ld_val = CNT_BOT;
        step   = 1'b0;
        down   = 1'b0;
        case (s_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    s_d.phase   = PH_COARSE;
                    s_d.tripped = 1'b0;
                    ld          = 1'b1;
                    ld_val      = CNT_TOP;
                end
            end
            PH_COARSE: begin
                step = 1'b1;
                down = 1'b1;
                if (!s_q.tripped && (cmp_i || cnt == CNT_BOT)) begin
                    s_d.coarse  = cnt;
                    s_d.tripped = 1'b1;
                end
                if (cnt == CNT_BOT) begin
                    s_d.phase   = PH_FINE;
                    s_d.tripped = 1'b0;
                    ld          = 1'b1;
                    ld_val      = CNT_BOT;
                end
            end
            PH_FINE: begin
                step = 1'b1;
                if (!s_q.tripped && (cmp_i || cnt == CNT_TOP)) begin
                    s_d.fine    = cnt;
                    s_d.tripped = 1'b1;
                end
                if (cnt == CNT_TOP) begin
                    s_d.phase = PH_IDLE;
                    s_d.done  = 1'b1;
                    ld        = 1'b1;
                    ld_val    = CNT_BOT;
                end
            end
            default: begin
                s_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{phase: PH_IDLE, tripped: 1'b0, coarse: '0, fine: '0, done: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign in_coarse = (s_q.phase == PH_COARSE);
    assign active    = (s_q.phase != PH_IDLE);
    assign dec_sel   = in_coarse ? cnt : s_q.coarse;

    tsc_ref_decoder #(.W(NIB_W)) u_dec (
        .sel_i  (dec_sel),
        .en_i   (active),
        .line_o (ref_line_o)
    );

    tsc_nibble_merge #(.W(NIB_W)) u_merge (
        .hi_i   (s_q.coarse),
        .lo_i   (s_q.fine),
        .code_o (code_o)
    );

    assign cnt_o        = cnt;
    assign coarse_sel_o = in_coarse;
    assign busy_o       = active;
    assign done_o       = s_q.done;

endmodule

// File: rtl/twostep_conv_seq_chk.sv
module twostep_conv_seq_chk #(
    parameter  int NIB_W  = 4,
    localparam int LEVELS = 1 << NIB_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [NIB_W-1:0]  cnt_o,
    input logic              coarse_sel_o,
    input logic [LEVELS-1:0] ref_line_o,
    input logic              busy_o,
    input logic              done_o
);

    assert_ref_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> ($countones(ref_line_o) == 1));

    assert_ref_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (ref_line_o == '0));

    assert_coarse_step_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (coarse_sel_o && $past(coarse_sel_o)) |-> (cnt_o == NIB_W'($past(cnt_o) - 1'b1)));

    assert_fine_ref_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !coarse_sel_o && $past(busy_o && !coarse_sel_o)) |-> $stable(ref_line_o));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_at_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> (busy_o || done_o));

endmodule

bind twostep_conv_seq twostep_conv_seq_chk #(.NIB_W(NIB_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .cnt_o        (cnt_o),
    .coarse_sel_o (coarse_sel_o),
    .ref_line_o   (ref_line_o),
    .busy_o       (busy_o),
    .done_o       (done_o)
);

// File: tb/twostep_conv_seq_bench.sv
module twostep_conv_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        cmp;
    logic [3:0]  cnt;
    logic        csel;
    logic [15:0] refl;
    logic        busy;
    logic        done;
    logic [7:0]  code;

    int checks = 0;
    int errors = 0;

    int mode = 0;
    int tc = 0;
    int tf = 0;
    int pa = 0;
    int pb = 0;

    always #5 clk = ~clk;

    twostep_conv_seq u_twostep_conv_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .cmp_i        (cmp),
        .cnt_o        (cnt),
        .coarse_sel_o (csel),
        .ref_line_o   (refl),
        .busy_o       (busy),
        .done_o       (done),
        .code_o       (code)
    );

    // Behavioural comparator: threshold model or two-spike model.
    always_comb begin
        if (!busy) cmp = 1'b0;
        else if (mode == 0) cmp = csel ? (int'(cnt) <= tc) : (int'(cnt) >= tf);
        else cmp = (int'(cnt) == pa) || (int'(cnt) == pb);
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_conv(input int ec, input int ef, input bit poke);
        int exp_code;
        exp_code = ((ec * 16) - ef) & 255;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        for (int i = 0; i < 32; i++) begin
            start = poke && (i == 9 || i == 31);
            chk(busy == 1'b1, "R8 busy during conversion", int'(busy), 1);
            if (i < 16) begin
                chk(csel == 1'b1, "R2 coarse select", int'(csel), 1);
                chk(int'(cnt) == 15 - i, "R2 coarse count down", int'(cnt), 15 - i);
                chk(refl == (16'd1 << (15 - i)), "R2 coarse ref line", int'(refl), 1 << (15 - i));
            end else begin
                chk(csel == 1'b0, "R5 fine select", int'(csel), 0);
                chk(int'(cnt) == i - 16, "R5 fine count up", int'(cnt), i - 16);
                chk(refl == (16'd1 << ec), "R3 R4 R5 fine ref holds coarse", int'(refl), 1 << ec);
            end
            chk(done == 1'b0, "R8 no early done", int'(done), 0);
            @(negedge clk);
        end
        start = 1'b0;
        chk(done == 1'b1, "R8 done after 32 cycles", int'(done), 1);
        chk(busy == 1'b0, "R8 idle at done", int'(busy), 0);
        chk(int'(code) == exp_code, "R6 R7 merged code", int'(code), exp_code);
        @(negedge clk);
        chk(done == 1'b0, "R8 done one cycle", int'(done), 0);
        chk(busy == 1'b0, "R9 no restart from ignored start", int'(busy), 0);
        chk(refl == 16'd0, "R10 idle lines low", int'(refl), 0);
    endtask

    initial begin
        #(10 * 200000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R1 reset busy", int'(busy), 0);
        chk(done == 1'b0, "R1 reset done", int'(done), 0);
        chk(refl == 16'd0, "R1 reset lines", int'(refl), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(csel == 1'b0, "R1 reset select", int'(csel), 0);
        chk(cnt == 4'd0, "R1 reset count", int'(cnt), 0);
        chk(refl == 16'd0, "R1 R10 idle lines", int'(refl), 0);

        // Exhaustive threshold sweep; tc=-1 never trips coarse (R4), tf=16 never trips fine.
        mode = 0;
        for (int c = -1; c <= 15; c++) begin
            for (int f = 0; f <= 16; f++) begin
                int ec;
                int ef;
                tc = c;
                tf = f;
                ec = (c < 0) ? 0 : c;
                ef = (f > 15) ? 15 : f;
                run_conv(ec, ef, ((c + f + 5) % 5) == 0);
            end
        end

        // Two spikes per pass: the later one must be ignored (R3, R6).
        mode = 1;
        for (int k = 0; k < 6; k++) begin
            int a;
            int b;
            a = (k * 7 + 3) % 16;
            b = (k * 11 + 9) % 16;
            pa = a;
            pb = b;
            run_conv((a > b) ? a : b, (a < b) ? a : b, k[0]);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule